// File: doc/BRIEF.md
# Double-Width Rate Match FIFO

This block is an elastic buffer between a recovered write clock and a local read clock. Each clock carries one 20-bit word made of two 10-bit symbols. The low symbol is the earlier one in time. The two clocks run at nearly the same rate, so the buffer slowly fills or drains. It corrects this by editing idle padding in the stream. An idle cluster is a control symbol followed by skip symbols. When the buffer runs too full, the write side discards a word whose two lanes are both skip symbols inside a cluster. When it runs too empty, the read side emits an extra all-skip word without consuming anything from storage.

Edits are always a whole word, so skip symbols are added or removed two at a time. Two skip symbols that fall in different words are never removed. After reset, both pointers clear. The read side stays silent until storage reaches half depth, and then it streams one word per read clock. Pointers cross the clock domains in Gray code through two-flop synchronizers.

Top module: `rate_match_dw`

## Requirements
- R1: A symbol counts as a control symbol when it equals CTRL_CODE or its bitwise complement, and as a skip symbol when it equals SKIP_CODE or its complement. Lane [9:0] is the first symbol of a word and lane [19:10] is the second. A cluster begins at a control symbol in either lane and continues through every skip symbol that follows it directly.
- R2: Every written word that is not deleted appears at rd_data exactly once, unchanged, and in write order.
- R3: A word is deleted only when all three hold: both lanes are skip symbols, the symbol just before it belongs to a cluster, and write-side occupancy is above DEL_ABOVE (12). A deleted word is not stored, and wr_deleted is high for the one write cycle that follows the accepted word.
- R4: A word with only one skip lane is never deleted, so skip symbols that are split across two words always pass through.
- R5: When read occupancy is below INS_BELOW (4) and the last word output left the stream inside a cluster, the block outputs {SKIP_CODE, SKIP_CODE} with rd_valid and rd_inserted high in the same cycle. The read pointer holds during that cycle.
- R6: Each inserted word follows a word read from storage, so rd_inserted is never high in two cycles without a stored word between them.
- R7: After reset, rd_valid stays low until read occupancy has reached DEPTH/2 (8).
- R8: While reset is held, rd_valid, rd_inserted and wr_deleted are low.
- R9: No word is written into a full buffer, so no stored word is ever overwritten.
- R10: Once streaming, if storage is empty and no insertion is allowed, rd_valid is low for that cycle and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | wr_data carries a word this cycle |
| wr_data | input | 20 | Incoming word; [9:0] first symbol, [19:10] second |
| wr_deleted | output | 1 | One-cycle pulse: the previous accepted word was dropped |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_data | output | 20 | Outgoing word, registered |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| rd_inserted | output | 1 | One-cycle pulse: rd_data is an inserted skip pair |

## Verification
A wrong pointer or cluster state in this block shows up at rd_data as a swapped, repeated or missing word. The bench catches this on the very next word it compares against its ordered record of writes. A wrong cluster state in the write domain shows one write cycle later, as a wr_deleted pulse for a word that was not a skip pair in a cluster. A wrong cluster state in the read domain shows as an inserted word that does not follow a cluster symbol. A lost or duplicated word leaves the record out of step for the rest of the run and, at the latest, leaves words unaccounted for after the final drain.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    localparam int SYM_W  = 10;
    localparam int WORD_W = 2 * SYM_W;

    // true when a symbol matches a code in either running-disparity form
    function automatic logic sym_is(input logic [SYM_W-1:0] s, input logic [SYM_W-1:0] code);
        return (s == code) || (s == ~code);
    endfunction

    // true when both lanes of a word are skip symbols
    function automatic logic skip_pair(input logic [WORD_W-1:0] w, input logic [SYM_W-1:0] skip);
        return sym_is(w[SYM_W-1:0], skip) && sym_is(w[WORD_W-1:SYM_W], skip);
    endfunction

    // cluster state after a word: the last symbol is a control symbol,
    // or a skip symbol that continues a cluster
    function automatic logic cluster_next(input logic prev, input logic [WORD_W-1:0] w,
                                          input logic [SYM_W-1:0] ctrl, input logic [SYM_W-1:0] skip);
        logic after_lo;
        after_lo = sym_is(w[SYM_W-1:0], ctrl) || (sym_is(w[SYM_W-1:0], skip) && prev);
        return sym_is(w[WORD_W-1:SYM_W], ctrl) || (sym_is(w[WORD_W-1:SYM_W], skip) && after_lo);
    endfunction

endpackage

// File: rtl/rmf_ptr_sync.sv
module rmf_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q, meta_d;
    logic [PW-1:0] sync_q, sync_d;
    logic [PW-1:0] bin_d;

    always_comb begin
        logic acc;
        meta_d = gray_in;
        sync_d = meta_q;
        acc    = 1'b0;
        for (int i = PW - 1; i >= 0; i--) begin
            acc      = acc ^ sync_q[i];
            bin_d[i] = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign bin_out = bin_d;
endmodule

// File: rtl/rmf_mem.sv
module rmf_mem #(
    parameter int DEPTH = 16,
    parameter int W     = 20,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/rmf_wr_ctrl.sv
module rmf_wr_ctrl
    import rmf_pkg::*;
#(
    parameter int               DEPTH     = 16,
    parameter int               DEL_ABOVE = 12,
    parameter logic [SYM_W-1:0] CTRL_CODE = 10'h0FA,
    parameter logic [SYM_W-1:0] SKIP_CODE = 10'h0F4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [PW-1:0]     rptr_bin,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [PW-1:0]     wgray,
    output logic              deleted
);
    localparam logic [PW-1:0] DEL_LIM = PW'(DEL_ABOVE);
    localparam logic [PW-1:0] FULL    = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic          clus;
        logic          del;
    } wst_t;

    wst_t          q, d;
    logic [PW-1:0] occ;
    logic          can_drop;
    logic          we_d;

    assign occ = q.wptr - rptr_bin;

    always_comb begin
        d        = q;
        d.del    = 1'b0;
        we_d     = 1'b0;
        can_drop = q.clus && skip_pair(in_data, SKIP_CODE);
        if (in_valid) begin
            d.clus = cluster_next(q.clus, in_data, CTRL_CODE, SKIP_CODE);
            if (can_drop && (occ > DEL_LIM)) begin
                d.del = 1'b1;
            end else if (occ != FULL) begin
                we_d   = 1'b1;
                d.wptr = q.wptr + 1'b1;
            end
        end
        d.wgray = d.wptr ^ (d.wptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign we      = we_d;
    assign waddr   = q.wptr[AW-1:0];
    assign wgray   = q.wgray;
    assign deleted = q.del;

    // R3: no drop unless the buffer is above its high mark
    p_del_needs_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (occ <= DEL_LIM)) |=> !q.del);
    // R3: a dropped word leaves the write pointer where it was
    p_del_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.del |-> (q.wptr == $past(q.wptr)));
    // R4: a word with a non-skip lane is never dropped
    p_single_lane_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !skip_pair(in_data, SKIP_CODE)) |=> !q.del);
    // R9: never write into a full buffer
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (occ != FULL));
endmodule

// File: rtl/rmf_rd_ctrl.sv
module rmf_rd_ctrl
    import rmf_pkg::*;
#(
    parameter int               DEPTH     = 16,
    parameter int               INS_BELOW = 4,
    parameter logic [SYM_W-1:0] CTRL_CODE = 10'h0FA,
    parameter logic [SYM_W-1:0] SKIP_CODE = 10'h0F4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     wptr_bin,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_ins
);
    localparam logic [PW-1:0]     INS_LIM   = PW'(INS_BELOW);
    localparam logic [PW-1:0]     FILL_LVL  = PW'(DEPTH / 2);
    localparam logic [WORD_W-1:0] SKIP_WORD = {SKIP_CODE, SKIP_CODE};

    typedef struct packed {
        logic [PW-1:0]     rptr;
        logic [PW-1:0]     rgray;
        logic              primed;
        logic              clus;
        logic              ins_last;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              ins;
    } rst_t;

    rst_t          q, d;
    logic [PW-1:0] occ;

    assign occ = wptr_bin - q.rptr;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ins   = 1'b0;
        if (!q.primed) begin
            if (occ >= FILL_LVL) d.primed = 1'b1;
        end else if (q.clus && !q.ins_last && (occ < INS_LIM)) begin
            d.data     = SKIP_WORD;
            d.valid    = 1'b1;
            d.ins      = 1'b1;
            d.ins_last = 1'b1;
        end else if (occ != '0) begin
            d.data     = mem_rdata;
            d.valid    = 1'b1;
            d.rptr     = q.rptr + 1'b1;
            d.ins_last = 1'b0;
            d.clus     = cluster_next(q.clus, mem_rdata, CTRL_CODE, SKIP_CODE);
        end
        d.rgray = d.rptr ^ (d.rptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raddr     = q.rptr[AW-1:0];
    assign rgray     = q.rgray;
    assign out_data  = q.data;
    assign out_valid = q.valid;
    assign out_ins   = q.ins;

    // R5: an inserted word is a valid skip pair
    p_ins_skip_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ins |-> (q.valid && (q.data == SKIP_WORD)));
    // R5: insertion consumes nothing from storage
    p_ins_holds_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ins |-> (q.rptr == $past(q.rptr)));
    // R6: two insertions always have a stored word between them
    p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.ins |=> !q.ins);
    // R7: no output before the half-depth fill
    p_fill_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> q.primed);
    // R10: a stored word is only output when storage held one
    p_empty_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !q.ins) |-> ($past(occ) != '0));
endmodule

// File: rtl/rate_match_dw.sv
module rate_match_dw
    import rmf_pkg::*;
#(
    parameter int               DEPTH     = 16,
    parameter int               DEL_ABOVE = 12,
    parameter int               INS_BELOW = 4,
    parameter logic [SYM_W-1:0] CTRL_CODE = 10'h0FA,
    parameter logic [SYM_W-1:0] SKIP_CODE = 10'h0F4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_deleted,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_inserted
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [PW-1:0]     wgray, rgray;
    logic [PW-1:0]     wptr_in_rd, rptr_in_wr;
    logic [WORD_W-1:0] mem_rdata;

    rmf_wr_ctrl #(
        .DEPTH(DEPTH), .DEL_ABOVE(DEL_ABOVE),
        .CTRL_CODE(CTRL_CODE), .SKIP_CODE(SKIP_CODE)
    ) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .in_valid(wr_valid), .in_data(wr_data),
        .rptr_bin(rptr_in_wr),
        .we(we), .waddr(waddr), .wgray(wgray),
        .deleted(wr_deleted)
    );

    rmf_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    rmf_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray), .bin_out(wptr_in_rd)
    );

    rmf_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rgray), .bin_out(rptr_in_wr)
    );

    rmf_rd_ctrl #(
        .DEPTH(DEPTH), .INS_BELOW(INS_BELOW),
        .CTRL_CODE(CTRL_CODE), .SKIP_CODE(SKIP_CODE)
    ) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .wptr_bin(wptr_in_rd), .mem_rdata(mem_rdata),
        .raddr(raddr), .rgray(rgray),
        .out_data(rd_data), .out_valid(rd_valid), .out_ins(rd_inserted)
    );
endmodule

// File: tb/sim_rate_match_dw.sv
module sim_rate_match_dw;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int         DEPTH = 16;
    localparam logic [9:0] CTRL  = 10'h0FA;
    localparam logic [9:0] SKIP  = 10'h0F4;

    logic        wr_clk, rd_clk, rst_n;
    logic        wr_valid, wr_deleted, rd_valid, rd_inserted;
    logic [19:0] wr_data, rd_data;

    real wr_half = 9.5;
    initial wr_clk = 1'b0;
    always #(wr_half) wr_clk = ~wr_clk;
    initial rd_clk = 1'b0;
    always #10 rd_clk = ~rd_clk;   // 50 MHz read clock

    rate_match_dw u0 (
        .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_deleted(wr_deleted), .rd_clk(rd_clk), .rd_rst_n(rst_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_inserted(rd_inserted)
    );

    int n_chk = 0, n_bad = 0, n_del = 0, n_ins = 0, pushed = 0;
    bit rd_go = 0, seen_valid = 0, prev_ins = 0, rclus = 0, wclus = 0;
    bit last_v = 0;
    logic [19:0] last_w;
    logic [19:0] exp_q[$];
    logic [19:0] pend[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_sym(input logic [9:0] s, input logic [9:0] c);
        return (s == c) || (s == ~c);
    endfunction

    function automatic bit clus_after(input bit prev, input logic [19:0] w);
        bit a;
        a = is_sym(w[9:0], CTRL) || (is_sym(w[9:0], SKIP) && prev);
        return is_sym(w[19:10], CTRL) || (is_sym(w[19:10], SKIP) && a);
    endfunction

    // R1: control and skip symbols in either disparity form
    function automatic logic [9:0] ct();
        return ($urandom_range(0, 1) != 0) ? CTRL : ~CTRL;
    endfunction
    function automatic logic [9:0] sk();
        return ($urandom_range(0, 1) != 0) ? SKIP : ~SKIP;
    endfunction
    function automatic logic [9:0] dt();
        logic [9:0] s;
        s = 10'($urandom);
        while (is_sym(s, CTRL) || is_sym(s, SKIP)) s = 10'($urandom);
        return s;
    endfunction

    task automatic fill_pattern();
        int pick = $urandom_range(0, 9);
        int k    = $urandom_range(1, 3);
        case (pick)
            4, 5: begin // control in high lane, whole skip pairs follow
                pend.push_back({ct(), dt()});
                for (int i = 0; i < k; i++) pend.push_back({sk(), sk()});
            end
            6: begin    // control low, skip high, lone skip in next low lane
                pend.push_back({sk(), ct()});
                pend.push_back({dt(), sk()});
            end
            7: begin    // control low, skip high, then pairs
                pend.push_back({sk(), ct()});
                for (int i = 0; i < k; i++) pend.push_back({sk(), sk()});
            end
            8: begin    // skip pair outside any cluster
                pend.push_back({dt(), dt()});
                pend.push_back({sk(), sk()});
            end
            9: pend.push_back({dt(), ct()});
            default: pend.push_back({dt(), dt()});
        endcase
    endtask

    task automatic wr_cycle(input bit v);
        logic [19:0] w;
        @(negedge wr_clk);
        if (last_v) begin
            if (wr_deleted) begin
                n_del++;
                check(is_sym(last_w[9:0], SKIP) && is_sym(last_w[19:10], SKIP), "R4",
                      "dropped word has a non-skip lane", last_w, {SKIP, SKIP});
                check(last_ok, "R1/R3", "dropped pair not inside a cluster", last_w, {SKIP, SKIP});
            end else begin
                exp_q.push_back(last_w);
                pushed++;
            end
        end else begin
            check(wr_deleted == 1'b0, "R3", "drop flag without a word", wr_deleted, 0);
        end
        if (v) begin
            if (pend.size() == 0) fill_pattern();
            w       = pend.pop_front();
            last_ok = wclus && is_sym(w[9:0], SKIP) && is_sym(w[19:10], SKIP);
            wclus   = clus_after(wclus, w);
            wr_data  = w;
            wr_valid = 1'b1;
            last_w   = w;
            last_v   = 1'b1;
        end else begin
            wr_valid = 1'b0;
            last_v   = 1'b0;
        end
    endtask
    bit last_ok = 0;

    initial begin
        wait (rd_go);
        forever begin
            @(negedge rd_clk);
            if (!rd_valid) begin
                check(rd_inserted == 1'b0, "R10", "insert flag without valid", rd_inserted, 0);
            end else begin
                if (!seen_valid) begin
                    seen_valid = 1;
                    check(pushed >= DEPTH / 2, "R7", "output before half fill", pushed, DEPTH / 2);
                end
                if (rd_inserted) begin
                    n_ins++;
                    check(rd_data == {SKIP, SKIP}, "R5", "inserted word", rd_data, {SKIP, SKIP});
                    check(rclus, "R5", "insert outside cluster", rclus, 1);
                    check(!prev_ins, "R6", "back-to-back insert", prev_ins, 0);
                    prev_ins = 1;
                end else if (exp_q.size() == 0) begin
                    check(0, "R2/R10", "word from empty buffer", rd_data, 0);
                end else begin
                    check(rd_data == exp_q[0], "R2", "data order", rd_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    rclus    = clus_after(rclus, rd_data);
                    prev_ins = 0;
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R8", "rd_valid in reset", rd_valid, 0);
        check(rd_inserted == 1'b0, "R8", "rd_inserted in reset", rd_inserted, 0);
        check(wr_deleted == 1'b0, "R8", "wr_deleted in reset", wr_deleted, 0);
        rst_n = 1'b1;
        rd_go = 1;
        repeat (20) wr_cycle(0);
        check(rd_valid == 1'b0, "R7", "valid with empty buffer", rd_valid, 0);
        // writer faster than reader: drops expected
        repeat (2500) wr_cycle(1);
        // writer slower and gapped: insertions and empty cycles expected
        wr_half = 11.5;
        repeat (2500) wr_cycle($urandom_range(0, 3) != 0);
        repeat (60) wr_cycle(0);
        repeat (100) @(negedge rd_clk);
        check(n_del > 0, "R3", "no pair was dropped under fill", n_del, 1);
        check(n_ins > 0, "R5", "no pair was inserted under drain", n_ins, 1);
        check(exp_q.size() == 0, "R2/R9", "words left unread", exp_q.size(), 0);
        finish_run();
    end
endmodule